// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of general-purpose pins, up to 32 of them, with its own register file on a plain 32-bit read/write bus. Each pin can be set to drive or to listen. A driving pin outputs a stored value, and that value can be made to flash on its own from a shared free-running timer. A listening pin is passed through a synchroniser. A per-pin invert is then applied, and the result is both readable and the source for interrupt detection.

Interrupts are recorded per pin in a cause register. Two mask registers decide whether a pin is treated as edge-triggered or level-triggered. The pending pins are ORed together in groups of eight, and each group drives one active-high level interrupt line. Falling-edge and low-level interrupts need no extra logic: software sets the pin's invert bit and uses the rising or high detection.

Top module: `gpio_bank_irq`

## Requirements
- R1: Word address 1 is the direction register, and it resets to all ones. A one bit makes the pin an input (`pad_oe` low). A zero bit drives `pad_out` from the output value register at word address 0. `pad_oe` follows a write one clock after the write edge.
- R2: Reading word address 4 returns the synchronised pad level XOR the invert register at word address 3. A pad change becomes readable after two clock edges, and a change to the invert register shows up right after its write edge. Writes to address 4 have no effect.
- R3: A pin whose bit is set in the flash register at word address 2 outputs its stored value XOR a shared phase bit. The phase is low after reset and toggles every 2^(BLINK_BITS-1) clocks, which gives a period of 2^BLINK_BITS clocks (default 2^24). All flashing pins are in phase.
- R4: A rising edge of the inverted-and-synchronised input sets the pin's bit in the cause register at word address 5. The bit is set on the third clock edge after the pad change, whatever the mask settings.
- R5: Writing the cause register clears each bit written as zero and keeps each bit written as one. If a new edge arrives in the same cycle as the clear, the edge wins.
- R6: For a pin whose bit is set in the level mask at word address 7, the cause bit takes the adjusted input level on every clock. A clearing write therefore has no lasting effect while the level stays high.
- R7: A pin is pending when its cause bit is set and its bit in the edge mask (word address 6) or the level mask is set. `irq[g]` is high when any of pins 8g to 8g+7 is pending.
- R8: Reset leaves every pin as an input. The output value, flash, invert, both masks and the cause register are all zero after reset, and every `irq` line is low.
- R9: Setting a pin's invert bit turns a falling pad edge into a rising adjusted edge. With the edge mask set, that falling edge raises the pin's group interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Pad drive values |
| pad_oe | output | NPINS | Pad drive enable, high = drive |
| irq | output | NPINS/8 | Group interrupt lines, active high |

## Verification
Register writes take effect at the next clock edge. The bench drives writes at a falling edge and looks at `pad_oe`, `pad_out` and `irq` one falling edge later. A pad change needs two edges to reach the data-in view and a third edge to reach the cause register and `irq`. The edge test therefore checks that `irq` is still low after two edges and high after three. A behavioural model runs on the same rising edges and is compared with every output at each falling edge. The flash test uses a reduced timer width so that a full half-period fits in the run.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int BUS_W = 32;

   typedef enum logic [2:0] {
      REG_DOUT  = 3'd0,
      REG_DIR   = 3'd1,
      REG_FLASH = 3'd2,
      REG_INV   = 3'd3,
      REG_DIN   = 3'd4,
      REG_CAUSE = 3'd5,
      REG_EMASK = 3'd6,
      REG_LMASK = 3'd7
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
   parameter int BITS = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   if (BITS < 2) begin : g_bad_bits
      $error("gpio_blink_timer: BITS must be at least 2");
   end

   logic [BITS-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign phase = cnt_q[BITS-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int NPINS = 32,
   parameter int GROUP = 8,
   localparam int NGRP = NPINS / GROUP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] adj,
   input  logic [NPINS-1:0] emask,
   input  logic [NPINS-1:0] lmask,
   input  logic             clr_we,
   input  logic [NPINS-1:0] clr_data,
   output logic [NPINS-1:0] cause,
   output logic [NPINS-1:0] rise,
   output logic [NGRP-1:0]  irq
);
   logic [NPINS-1:0] prev_q, cause_q, cause_nxt, pend;

   assign rise = adj & ~prev_q;

   always_comb begin
      cause_nxt = cause_q;
      if (clr_we) cause_nxt = cause_nxt & clr_data;
      cause_nxt = cause_nxt | rise;
      cause_nxt = (cause_nxt & ~lmask) | (adj & lmask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         cause_q <= '0;
      end else begin
         prev_q  <= adj;
         cause_q <= cause_nxt;
      end
   end

   assign cause = cause_q;
   assign pend  = cause_q & (emask | lmask);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign irq[g] = |pend[g*GROUP +: GROUP];
   end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int GROUP       = 8,
   parameter int BLINK_BITS  = 24,
   parameter int SYNC_STAGES = 2,
   localparam int NGRP = NPINS / GROUP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NGRP-1:0]  irq
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_bank_irq: NPINS must be 1..32");
   end
   if (GROUP < 1 || (NPINS % GROUP) != 0) begin : g_bad_group
      $error("gpio_bank_irq: NPINS must be a multiple of GROUP");
   end

   logic             wr_en;
   logic [NPINS-1:0] wr_dat;
   logic [NPINS-1:0] dout_q, dir_q, blink_en, pol_q, emask_q, lmask_q;
   logic [NPINS-1:0] pin_sync, adj, cause, rise, rd_val;
   logic             phase;

   assign wr_en  = bus_sel & bus_wr;
   assign wr_dat = bus_wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dir_q    <= '1;
         blink_en <= '0;
         pol_q    <= '0;
         emask_q  <= '0;
         lmask_q  <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            REG_DOUT:  dout_q   <= wr_dat;
            REG_DIR:   dir_q    <= wr_dat;
            REG_FLASH: blink_en <= wr_dat;
            REG_INV:   pol_q    <= wr_dat;
            REG_EMASK: emask_q  <= wr_dat;
            REG_LMASK: lmask_q  <= wr_dat;
            default:   ;
         endcase
      end
   end

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   assign adj = pin_sync ^ pol_q;

   gpio_blink_timer #(.BITS(BLINK_BITS)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   assign pad_out = dout_q ^ (blink_en & {NPINS{phase}});
   assign pad_oe  = ~dir_q;

   gpio_irq_unit #(.NPINS(NPINS), .GROUP(GROUP)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .adj      (adj),
      .emask    (emask_q),
      .lmask    (lmask_q),
      .clr_we   (wr_en && bus_addr == REG_CAUSE),
      .clr_data (wr_dat),
      .cause    (cause),
      .rise     (rise),
      .irq      (irq)
   );

   always_comb begin
      case (bus_addr)
         REG_DOUT:  rd_val = dout_q;
         REG_DIR:   rd_val = dir_q;
         REG_FLASH: rd_val = blink_en;
         REG_INV:   rd_val = pol_q;
         REG_DIN:   rd_val = adj;
         REG_CAUSE: rd_val = cause;
         REG_EMASK: rd_val = emask_q;
         default:   rd_val = lmask_q;
      endcase
      bus_rdata              = '0;
      bus_rdata[NPINS-1:0]   = rd_val;
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int NPINS = 32,
   parameter int GROUP = 8,
   localparam int NGRP = NPINS / GROUP
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic [NPINS-1:0] pad_out,
   input logic [NPINS-1:0] pad_oe,
   input logic [NGRP-1:0]  irq,
   input logic [NPINS-1:0] blink_en,
   input logic [NPINS-1:0] emask,
   input logic [NPINS-1:0] lmask,
   input logic [NPINS-1:0] adj,
   input logic [NPINS-1:0] cause,
   input logic [NPINS-1:0] rise
);
   AST_DIR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == 3'd1) |=> (pad_oe == ~$past(bus_wdata[NPINS-1:0]))); // R1

   AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_en == '0 && !(bus_sel && bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd2)))
         |=> (pad_out == $past(pad_out))); // R3

   AST_CAUSE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == 3'd5 && bus_wdata[NPINS-1:0] == '0
         && lmask == '0 && rise == '0) |=> (cause == '0)); // R5

   AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause & $past(lmask)) == ($past(adj) & $past(lmask)))); // R6

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ((emask | lmask) == '0) |-> (irq == '0)); // R7
endmodule

bind gpio_bank_irq gpio_bank_chk #(.NPINS(NPINS), .GROUP(GROUP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .blink_en  (blink_en),
   .emask     (emask_q),
   .lmask     (lmask_q),
   .adj       (adj),
   .cause     (cause),
   .rise      (rise)
);

// File: tb/sim_gpio_bank_irq.sv
`timescale 1ns/1ps
module sim_gpio_bank_irq;
   localparam int BB = 6;
   localparam int NP = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic [3:0]  irq;

   int errors = 0, checks = 0, cyc = 0;

   gpio_bank_irq #(.NPINS(NP), .GROUP(8), .BLINK_BITS(BB)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

   always #10 clk = ~clk;

   // behavioural reference model
   logic [31:0] m_dout, m_dir, m_blk, m_pol, m_em, m_lm, m_cause, m_s1, m_s2, m_prev;
   int m_cnt;

   always @(posedge clk) begin
      logic [31:0] a, r, c;
      if (!rst_n) begin
         m_dout = 0; m_dir = '1; m_blk = 0; m_pol = 0; m_em = 0; m_lm = 0;
         m_cause = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0;
      end else begin
         a = m_s2 ^ m_pol;
         r = a & ~m_prev;
         c = m_cause;
         if (bus_sel && bus_wr && bus_addr == 3'd5) c = c & bus_wdata;
         c = c | r;
         for (int i = 0; i < NP; i++) if (m_lm[i]) c[i] = a[i];
         m_cause = c;
         m_prev = a;
         m_s2 = m_s1;
         m_s1 = pad_in;
         m_cnt = (m_cnt + 1) % (1 << BB);
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               3'd0: m_dout = bus_wdata;
               3'd1: m_dir  = bus_wdata;
               3'd2: m_blk  = bus_wdata;
               3'd3: m_pol  = bus_wdata;
               3'd6: m_em   = bus_wdata;
               3'd7: m_lm   = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_out();
      logic ph = ((m_cnt >> (BB - 1)) & 1) != 0;
      return m_dout ^ (m_blk & {32{ph}});
   endfunction

   function automatic logic [3:0] m_irq();
      logic [31:0] p = m_cause & (m_em | m_lm);
      logic [3:0] q;
      for (int g = 0; g < 4; g++) q[g] = |p[g*8 +: 8];
      return q;
   endfunction

   function automatic logic [31:0] m_read(input logic [2:0] ad);
      case (ad)
         3'd0: return m_dout;
         3'd1: return m_dir;
         3'd2: return m_blk;
         3'd3: return m_pol;
         3'd4: return m_s2 ^ m_pol;
         3'd5: return m_cause;
         3'd6: return m_em;
         default: return m_lm;
      endcase
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(pad_oe == ~m_dir, "R1 cycle pad_oe", pad_oe, ~m_dir);
         chk(pad_out == m_out(), "R3 cycle pad_out", pad_out, m_out());
         chk(irq == m_irq(), "R7 cycle irq", {28'd0, irq}, {28'd0, m_irq()});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] ad, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = ad; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] ad, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = ad;
      #2;
      chk(bus_rdata == exp, req, bus_rdata, exp);
      chk(bus_rdata == m_read(ad), {req, " model"}, bus_rdata, m_read(ad));
      bus_sel = 0;
   endtask

   task automatic pad(input logic [31:0] v);
      @(negedge clk);
      pad_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic v0;
      idle(3);
      rst_n = 1;
      // R8 reset state
      rd(3'd1, 32'hFFFF_FFFF, "R8 dir reset");
      rd(3'd5, 32'h0, "R8 cause reset");
      rd(3'd6, 32'h0, "R8 emask reset");
      chk(pad_oe == 0, "R8 pad_oe reset", pad_oe, 0);
      chk(irq == 0, "R8 irq reset", {28'd0, irq}, 0);

      // R1 direction and drive
      wr(3'd1, 32'hFFFF_0000);
      wr(3'd0, 32'h0000_A5A5);
      chk(pad_oe == 32'h0000_FFFF, "R1 pad_oe", pad_oe, 32'h0000_FFFF);
      chk(pad_out == 32'h0000_A5A5, "R1 pad_out", pad_out, 32'h0000_A5A5);

      // R2 synchronised input, invert, read-only view
      pad(32'h1234_0000);
      idle(1);
      rd(3'd4, 32'h1234_0000, "R2 data in after two edges");
      wr(3'd3, 32'h0000_00FF);
      rd(3'd4, 32'h1234_00FF, "R2 data in inverted");
      wr(3'd4, 32'hDEAD_BEEF);
      rd(3'd4, 32'h1234_00FF, "R2 write to data in ignored");
      wr(3'd3, 32'h0);
      pad(32'h0);
      idle(3);
      wr(3'd5, 32'h0);
      rd(3'd5, 32'h0, "R5 cause cleared");

      // R4/R7 edge recorded without a mask, no interrupt
      pad(32'h0001_0000);
      idle(3);
      chk(irq == 0, "R7 unmasked cause quiet", {28'd0, irq}, 0);
      rd(3'd5, 32'h0001_0000, "R4 cause set by rise");
      wr(3'd6, 32'h0001_0000);
      chk(irq == 4'b0100, "R7 edge mask raises group 2", {28'd0, irq}, 32'h4);

      // R5 write-one keeps, write-zero clears
      wr(3'd5, 32'hFFFF_FFFF);
      chk(irq == 4'b0100, "R5 write one keeps", {28'd0, irq}, 32'h4);
      wr(3'd5, ~32'h0001_0000);
      chk(irq == 4'b0000, "R5 write zero clears", {28'd0, irq}, 32'h0);

      // R4 edge timing: three edges from pad to irq
      wr(3'd6, 32'h0001_0100);
      pad(32'h0001_0100);
      idle(2);
      chk(irq == 4'b0000, "R4 not yet after two edges", {28'd0, irq}, 32'h0);
      idle(1);
      chk(irq == 4'b0010, "R4 irq after three edges", {28'd0, irq}, 32'h2);
      wr(3'd5, 32'h0);

      // R6 level mode
      wr(3'd7, 32'h0100_0000);
      pad(32'h0101_0100);
      idle(3);
      chk(irq == 4'b1000, "R6 level raises group 3", {28'd0, irq}, 32'h8);
      wr(3'd5, 32'h0);
      chk(irq == 4'b1000, "R6 clear has no lasting effect", {28'd0, irq}, 32'h8);
      pad(32'h0001_0100);
      idle(3);
      chk(irq == 4'b0000, "R6 level low clears", {28'd0, irq}, 32'h0);

      // R9 falling edge via invert
      wr(3'd7, 32'h0);
      wr(3'd6, 32'h0000_0001);
      pad(32'h0001_0101);
      idle(3);
      wr(3'd3, 32'h0000_0001);
      wr(3'd5, 32'h0);
      chk(irq == 4'b0000, "R9 quiet before fall", {28'd0, irq}, 32'h0);
      pad(32'h0001_0100);
      idle(3);
      chk(irq == 4'b0001, "R9 falling edge raises group 0", {28'd0, irq}, 32'h1);

      // R3 shared flash
      wr(3'd6, 32'h0);
      wr(3'd1, 32'hFFFF_FF00);
      wr(3'd2, 32'h0000_000C);
      v0 = pad_out[2];
      idle(32);
      chk(pad_out[2] != v0, "R3 toggled after half period", {31'd0, pad_out[2]}, {31'd0, ~v0});
      chk(pad_out[2] != pad_out[3], "R3 in phase", {31'd0, pad_out[2]}, {31'd0, ~pad_out[3]});
      idle(40);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule